// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence for one read or write burst of a synchronous DRAM. A controller pulses `start` together with the first column, a burst length code and an ordering select. From the next cycle the block emits one column address per clock. It keeps doing so until the programmed length has run out, a stop request arrives, or a new start replaces the burst.

The sequencer has three named states. `ST_IDLE` means no burst is running. `ST_FIXED` runs a burst of 1, 2, 4 or 8 beats. `ST_PAGE` runs an open-ended burst across the 512-column row. The transitions are as follows:
- IDLE to FIXED or PAGE on a start.
- FIXED to IDLE on its final beat or on a stop.
- PAGE to IDLE on a stop.
- FIXED or PAGE to FIXED or PAGE on a new start, which restarts the burst.

While `cke` is low, every register holds its value and the outputs are frozen.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While `rst_n` is low and after it rises, `col_valid` and `last_beat` are 0 and `col_out` is 0 until a start is accepted.
- R2: A start sampled with `cke` high makes `col_valid` 1 in the next cycle, with `col_out` equal to the sampled `start_col`.
- R3: With `bl_code` 3'b001, 3'b010 or 3'b011 (2, 4 or 8 beats) and `burst_ilv` 0, beat k gives address bits below log2(length) as (start + k) modulo length. The bits above log2(length) equal those of `start_col`.
- R4: With those lengths and `burst_ilv` 1, beat k gives the low log2(length) bits as the start bits XOR k. The upper bits are unchanged.
- R5: `bl_code` 3'b000 and the reserved codes 3'b100, 3'b101 and 3'b110 each give a single-beat burst.
- R6: `bl_code` 3'b111 selects a full page burst. It counts up by one column per beat, wraps from 511 to 0, ignores `burst_ilv`, never raises `last_beat`, and runs until stopped or restarted.
- R7: `last_beat` is 1 exactly on the final beat of a fixed-length burst. In the following cycle with `cke` high, `col_valid` falls unless a start is sampled.
- R8: `stop` sampled with `cke` high during a burst ends it, so `col_valid` is 0 in the next cycle. `stop` while idle has no effect.
- R9: On any clock edge where `cke` is low, all outputs keep their values, and `start` and `stop` are ignored.
- R10: A start during a burst restarts the sequence from the new `start_col` and mode, and it takes priority over a `stop` sampled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low freezes the generator |
| start | input | 1 | Begin a burst, sampled with cke high |
| start_col | input | 9 | First column of the burst |
| bl_code | input | 3 | Burst length code (see R3, R5, R6) |
| burst_ilv | input | 1 | 1 selects interleaved ordering, 0 linear |
| stop | input | 1 | End the running burst early |
| col_out | output | 9 | Column address of the current beat |
| col_valid | output | 1 | A beat is being presented |
| last_beat | output | 1 | Current beat is the final one of a fixed burst |

## Verification
Several properties are checked by the assertions on every cycle:
- the freeze while `cke` is low;
- the first beat carrying the sampled column;
- the drop of `col_valid` after a stop or after a final beat;
- the burst continuing while neither of those occurs.

Some behaviour can only be shown by the bench's scenarios, because it depends on the whole address sequence. This covers the exact linear wrap inside an aligned block, the interleaved XOR order, the full page wrap through column 0, and the single-beat treatment of reserved codes. The bench compares every beat against a model that computes these orders from the requirements.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } colgen_state_e;

    localparam logic [2:0] BLC_ONE  = 3'b000;
    localparam logic [2:0] BLC_TWO  = 3'b001;
    localparam logic [2:0] BLC_FOUR = 3'b010;
    localparam logic [2:0] BLC_EIGHT = 3'b011;
    localparam logic [2:0] BLC_PAGE = 3'b111;

endpackage

// File: rtl/colgen_len_decode.sv
module colgen_len_decode #(
    parameter int COL_W = 9
) (
    input  logic [2:0]       bl_code,
    output logic [COL_W-1:0] wrap_mask,
    output logic             is_page
);
    import sdram_colgen_pkg::*;

    // wrap_mask = burst length - 1 for fixed bursts; all ones for a page
    always_comb begin
        wrap_mask = '0;
        is_page   = 1'b0;
        unique case (bl_code)
            BLC_TWO:   wrap_mask = COL_W'(1);
            BLC_FOUR:  wrap_mask = COL_W'(3);
            BLC_EIGHT: wrap_mask = COL_W'(7);
            BLC_PAGE: begin
                wrap_mask = '1;
                is_page   = 1'b1;
            end
            default:   wrap_mask = '0;   // single beat, reserved codes too
        endcase
    end
endmodule

// File: rtl/colgen_addr_calc.sv
module colgen_addr_calc #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [COL_W-1:0] beat_cnt,
    input  logic [COL_W-1:0] wrap_mask,
    input  logic             ilv_mode,
    output logic [COL_W-1:0] beat_col
);
    logic [COL_W-1:0] low_part;

    always_comb begin
        if (ilv_mode) low_part = base_col ^ beat_cnt;
        else          low_part = base_col + beat_cnt;
        beat_col = (base_col & ~wrap_mask) | (low_part & wrap_mask);
    end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic [2:0]       bl_code,
    input  logic             burst_ilv,
    input  logic             stop,
    output logic [COL_W-1:0] col_out,
    output logic             col_valid,
    output logic             last_beat
);
    import sdram_colgen_pkg::*;

    colgen_state_e    state_q, state_d;
    logic [COL_W-1:0] base_q, base_d;
    logic [COL_W-1:0] cnt_q, cnt_d;
    logic [COL_W-1:0] mask_q, mask_d;
    logic             ilv_q, ilv_d;

    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    logic [COL_W-1:0] calc_col;
    logic             at_final;

    colgen_len_decode #(.COL_W(COL_W)) len_dec_i (
        .bl_code   (bl_code),
        .wrap_mask (dec_mask),
        .is_page   (dec_page)
    );

    colgen_addr_calc #(.COL_W(COL_W)) addr_calc_i (
        .base_col  (base_q),
        .beat_cnt  (cnt_q),
        .wrap_mask (mask_q),
        .ilv_mode  (ilv_q),
        .beat_col  (calc_col)
    );

    assign at_final = (state_q == ST_FIXED) && (cnt_q == mask_q);

    // next-state and datapath selection
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        cnt_d   = cnt_q;
        mask_d  = mask_q;
        ilv_d   = ilv_q;
        if (start) begin
            base_d  = start_col;
            cnt_d   = '0;
            mask_d  = dec_mask;
            ilv_d   = burst_ilv & ~dec_page;
            state_d = dec_page ? ST_PAGE : ST_FIXED;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_FIXED: begin
                    if (stop || at_final) state_d = ST_IDLE;
                    else                  cnt_d   = cnt_q + 1'b1;
                end
                ST_PAGE: begin
                    if (stop) state_d = ST_IDLE;
                    else      cnt_d   = cnt_q + 1'b1;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register; a low clock enable freezes everything
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            cnt_q   <= '0;
            mask_q  <= '0;
            ilv_q   <= 1'b0;
        end else if (cke) begin
            state_q <= state_d;
            base_q  <= base_d;
            cnt_q   <= cnt_d;
            mask_q  <= mask_d;
            ilv_q   <= ilv_d;
        end
    end

    // outputs
    always_comb begin
        col_valid = (state_q != ST_IDLE);
        col_out   = col_valid ? calc_col : '0;
        last_beat = at_final;
    end
endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
    parameter int COL_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cke,
    input logic             start,
    input logic [COL_W-1:0] start_col,
    input logic             stop,
    input logic [COL_W-1:0] col_out,
    input logic             col_valid,
    input logic             last_beat
);
    assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(col_out) && $stable(col_valid) && $stable(last_beat)))
        else $error("freeze violated");

    assert_first_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && start) |=> (col_valid && col_out == $past(start_col)))
        else $error("first beat wrong");

    assert_stop_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && stop && !start) |=> !col_valid)
        else $error("stop ignored");

    assert_final_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && last_beat && !start) |=> !col_valid)
        else $error("burst ran past final beat");

    assert_last_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat |-> col_valid)
        else $error("last_beat without valid");

    assert_continues_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && col_valid && !last_beat && !stop) |=> col_valid)
        else $error("burst dropped early");
endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .start     (start),
    .start_col (start_col),
    .stop      (stop),
    .col_out   (col_out),
    .col_valid (col_valid),
    .last_beat (last_beat)
);

// File: tb/sdram_burst_colgen_tb_top.sv
module sdram_burst_colgen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       start = 1'b0;
    logic [8:0] start_col = '0;
    logic [2:0] bl_code = '0;
    logic       burst_ilv = 1'b0;
    logic       stop = 1'b0;
    logic [8:0] col_out;
    logic       col_valid;
    logic       last_beat;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    bit m_act = 0, m_page = 0, m_ilv = 0;
    int m_len = 1, m_base = 0, m_cnt = 0;

    always #5 clk = ~clk;

    sdram_burst_colgen dut_i (
        .clk(clk), .rst_n(rst_n), .cke(cke), .start(start),
        .start_col(start_col), .bl_code(bl_code), .burst_ilv(burst_ilv),
        .stop(stop), .col_out(col_out), .col_valid(col_valid),
        .last_beat(last_beat)
    );

    function automatic int len_of(input logic [2:0] c);
        case (c)
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return 8;
            3'b111: return 512;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col();
        int off;
        if (m_page) return (m_base + m_cnt) % 512;
        off = m_base % m_len;
        if (m_ilv) return (m_base - off) + (off ^ m_cnt);
        return (m_base - off) + ((off + m_cnt) % m_len);
    endfunction

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit k, input bit s, input int col, input logic [2:0] c,
                        input bit il, input bit sp, input string tag);
        @(negedge clk);
        cke = k; start = s; start_col = 9'(col); bl_code = c; burst_ilv = il; stop = sp;
        @(posedge clk);
        if (k) begin
            if (s) begin
                m_act = 1; m_page = (c == 3'b111); m_len = len_of(c);
                m_base = col; m_cnt = 0; m_ilv = il && !m_page;
            end else if (m_act) begin
                if (sp) m_act = 0;
                else if (!m_page && m_cnt == m_len - 1) m_act = 0;
                else m_cnt = (m_cnt + 1) % 512;
            end
        end
        #1;
        check(tag, int'(col_valid), int'(m_act), "col_valid");
        if (m_act) begin
            check(tag, int'(col_out), exp_col(), "col_out");
            check(tag, int'(last_beat), int'(!m_page && m_cnt == m_len - 1), "last_beat");
        end else begin
            check(tag, int'(last_beat), 0, "last_beat idle");
        end
    endtask

    task automatic idle_n(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, 0, 3'b000, 0, 0, tag);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1", int'(col_valid), 0, "reset col_valid");
        check("R1", int'(last_beat), 0, "reset last_beat");
        check("R1", int'(col_out), 0, "reset col_out");
        @(negedge clk); rst_n = 1'b1;
        idle_n(2, "R1");

        // R4: interleaved eight beats from 5 -> 5,4,7,6,1,0,3,2
        step(1, 1, 5, 3'b011, 1, 0, "R2");
        for (int i = 0; i < 8; i++) step(1, 0, 0, 3'b000, 0, 0, "R4");
        // R3: linear four beats from 6 -> 6,7,4,5 ; upper bits kept (0x106)
        step(1, 1, 9'h106, 3'b010, 0, 0, "R3");
        for (int i = 0; i < 5; i++) step(1, 0, 0, 3'b000, 0, 0, "R3");
        // R3 two beats
        step(1, 1, 9'h1FF, 3'b001, 0, 0, "R3");
        idle_n(3, "R7");
        // R5: single beat and reserved codes
        step(1, 1, 77, 3'b000, 1, 0, "R5"); idle_n(1, "R5");
        step(1, 1, 78, 3'b100, 0, 0, "R5"); idle_n(1, "R5");
        step(1, 1, 79, 3'b101, 1, 0, "R5"); idle_n(1, "R5");
        step(1, 1, 80, 3'b110, 0, 0, "R5"); idle_n(1, "R5");
        // R6: full page from 509 wraps through 0, ignores interleave
        step(1, 1, 509, 3'b111, 1, 0, "R6");
        for (int i = 0; i < 10; i++) step(1, 0, 0, 3'b000, 0, 0, "R6");
        // R9: freeze, start and stop ignored while cke low
        step(0, 1, 3, 3'b011, 0, 1, "R9");
        step(0, 0, 0, 3'b000, 0, 1, "R9");
        step(1, 0, 0, 3'b000, 0, 0, "R9");
        // R8: stop ends page burst; stop while idle no effect
        step(1, 0, 0, 3'b000, 0, 1, "R8");
        step(1, 0, 0, 3'b000, 0, 1, "R8");
        // R10: restart mid burst, start beats stop
        step(1, 1, 16, 3'b011, 0, 0, "R10");
        step(1, 0, 0, 3'b000, 0, 0, "R10");
        step(1, 1, 40, 3'b010, 1, 1, "R10");
        idle_n(5, "R10");
        // R7: last beat held frozen under cke low, then ends
        step(1, 1, 2, 3'b001, 0, 0, "R7");
        step(1, 0, 0, 3'b000, 0, 0, "R7");
        step(0, 0, 0, 3'b000, 0, 0, "R7");
        step(1, 0, 0, 3'b000, 0, 0, "R7");

        // constrained random
        for (int i = 0; i < 6000; i++) begin
            bit k, s, sp, il;
            logic [2:0] c;
            string tag;
            k  = ($urandom % 10) < 8;
            s  = ($urandom % 12) == 0;
            sp = ($urandom % 20) == 0;
            il = $urandom % 2;
            c  = 3'($urandom % 8);
            if (c == 3'b111 && ($urandom % 3) != 0) c = 3'b011;
            if (!k) tag = "R9";
            else if (s) tag = "R2";
            else if (sp) tag = "R8";
            else if (m_page) tag = "R6";
            else if (m_ilv) tag = "R4";
            else tag = "R3";
            step(k, s, int'($urandom % 512), c, il, sp, tag);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule